// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block carries out one register read or register write at a time on up to two serial front-end chips. The chips share one clock line and one bidirectional data line, and each chip has its own active-low select. A request gives a channel index, a 12-bit register address, a read/write flag and a 32-bit write word. The block shifts out a 48-bit frame and pulses `done_o` when the frame is finished. After a read, the 32 bits it captured appear on `rdata_o`.

The frame has a 16-bit header followed by 32 data bits. The header holds the register address, one mode bit and three zero bits. After the header the clock stays low for one extra half-period. On reads the master releases the data pin for the whole data phase. The clock half-period is a parameter counted in system clock cycles. Each bit is set up while the clock is low, then the clock is driven high for one half-period and low for one half-period. The clock rests low.

Top module: `spi3w_reg_master`

## Requirements
- R1: After reset, every `cs_no` bit is 1, and `sclk_o`, `sdio_oe_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: A request with `req_ch_i` below `N_CH` is taken only while `busy_o` is 0. From the cycle after acceptance, `cs_no[req_ch_i]` is 0 and every other select bit is 1, and `busy_o` is 1 until the done pulse.
- R3: The first 16 frame bits are the register address (bit 11 first), then the mode bit (1 = read, 0 = write), then three 0 bits. The output driver is enabled for all 16 bits.
- R4: On a write, frame bits 17 to 48 are `req_wdata_i`, bit 31 first, with `sdio_oe_o` high for every bit.
- R5: On a read, `sdio_oe_o` is 0 for all 32 data bits. `sdio_i` is sampled while `sclk_o` is low, just before each rising edge, and shifted into the lsb. After the frame, `rdata_o` holds the 32 bits in the order they arrived, first bit in bit 31.
- R6: A frame has exactly 48 clock pulses. Each pulse is high for `HALF_DIV` cycles, and the low time before each pulse is `HALF_DIV` cycles, except the case in R7.
- R7: The low time between pulse 16 and pulse 17 is `2*HALF_DIV` cycles.
- R8: The chip select is low for exactly `97*HALF_DIV` cycles. In the first cycle after that, `done_o` is high for one cycle, `busy_o` is 0 and all selects are high.
- R9: A request with `req_ch_i >= N_CH` while idle gives a one-cycle `err_o` pulse. It asserts no select and leaves `busy_o` at 0.
- R10: A request made while `busy_o` is 1 is ignored. The running frame and its select are not changed, and no second frame follows.
- R11: A write leaves `rdata_o` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ch_i | input | CH_W | Channel index |
| req_addr_i | input | ADDR_W | Register address |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_wdata_i | input | DATA_W | Write word |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at end of frame |
| err_o | output | 1 | One-cycle pulse on a bad channel index |
| rdata_o | output | DATA_W | Last word read |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | N_CH | Chip selects, active low |
| sdio_o | output | 1 | Data pin output value |
| sdio_oe_o | output | 1 | Data pin output enable |
| sdio_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with `HALF_DIV` set to 2 and keeps the defaults for the other parameters. A half-period of two cycles is still long enough to tell a one-half-period gap after the header from a two-half-period gap. It also keeps each frame under two hundred cycles, so many frames fit in the run. `CH_W` of 2 with `N_CH` of 2 makes the out-of-range indexes 2 and 3 available for the error path.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_GAP  = 2'd3
  } st_e;
endpackage

// File: rtl/spi3w_half_timer.sv
module spi3w_half_timer #(
  parameter int HALF_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi3w_cs_dec.sv
module spi3w_cs_dec #(
  parameter int N_CH = 2,
  parameter int CH_W = 2
) (
  input  logic            en_i,
  input  logic [CH_W-1:0] ch_i,
  output logic [N_CH-1:0] cs_no
);
  for (genvar g = 0; g < N_CH; g++) begin : g_cs
    assign cs_no[g] = !(en_i && (ch_i == CH_W'(g)));
  end
endmodule

// File: rtl/spi3w_reg_master.sv
module spi3w_reg_master
  import spi3w_pkg::*;
#(
  parameter int HALF_DIV = 5,
  parameter int N_CH     = 2,
  parameter int CH_W     = 2,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CH_W-1:0]   req_ch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_rd_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic [N_CH-1:0]   cs_no,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  input  logic              sdio_i
);
  localparam int HDR_W   = ADDR_W + 4;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  st_e                st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;
  logic [CH_W-1:0]    ch_q;
  logic               rd_q, done_q, err_q;
  logic               tick, ch_ok, in_data;

  assign ch_ok   = {1'b0, req_ch_i} < (CH_W+1)'(N_CH);
  assign in_data = idx_q >= IDX_W'(HDR_W);

  spi3w_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .tick_o (tick)
  );

  spi3w_cs_dec #(.N_CH(N_CH), .CH_W(CH_W)) u_cs (
    .en_i  (st_q != ST_IDLE),
    .ch_i  (ch_q),
    .cs_no (cs_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      ch_q   <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          if (ch_ok) begin
            st_q  <= ST_LO;
            ch_q  <= req_ch_i;
            rd_q  <= req_rd_i;
            idx_q <= '0;
            tx_q  <= {req_addr_i, req_rd_i, 3'b000, req_wdata_i};
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_LO: if (tick) begin
          // sample just before the rising edge
          if (rd_q && in_data) rx_q <= {rx_q[DATA_W-2:0], sdio_i};
          st_q <= ST_HI;
        end
        ST_HI: if (tick) begin
          tx_q  <= tx_q << 1;
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(FRAME_W - 1)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (idx_q == IDX_W'(HDR_W - 1)) begin
            st_q <= ST_GAP;
          end else begin
            st_q <= ST_LO;
          end
        end
        ST_GAP: if (tick) st_q <= ST_LO;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = st_q != ST_IDLE;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rdata_o   = rx_q;
  assign sclk_o    = st_q == ST_HI;
  assign sdio_o    = tx_q[FRAME_W-1];
  assign sdio_oe_o = busy_o && !(rd_q && in_data);
endmodule

// File: rtl/spi3w_reg_master_chk.sv
module spi3w_reg_master_chk #(
  parameter int N_CH = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic            sclk_o,
  input logic            sdio_oe_o,
  input logic [N_CH-1:0] cs_no
);
  assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ((&cs_no) && !sclk_o && !sdio_oe_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_err_no_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && (&cs_no) && !done_o));

  assert_cs_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cs_no));
endmodule

bind spi3w_reg_master spi3w_reg_master_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .sclk_o    (sclk_o),
  .sdio_oe_o (sdio_oe_o),
  .cs_no     (cs_no)
);

// File: tb/tb_spi3w_reg_master.sv
module tb_spi3w_reg_master;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 2;
  localparam int N_CH       = 2;
  localparam int CH_W       = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_ch_i = '0;
  logic [11:0] req_addr_i = '0;
  logic        req_rd_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        busy_o, done_o, err_o, sclk_o, sdio_o, sdio_oe_o, sdio_i;
  logic [31:0] rdata_o;
  logic [1:0]  cs_no;

  int          total = 0, bad = 0;
  bit          finished = 0;

  // monitor state
  int          cs_cnt, pulses, falls, lo_run, hi_run, lo_bad, hi_bad, gap_lo;
  logic [47:0] cap_d, cap_oe;
  logic [1:0]  cs_seen;
  logic        sclk_prev = 1'b0;
  logic [31:0] rdv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3w_reg_master #(.HALF_DIV(H), .N_CH(N_CH), .CH_W(CH_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ch_i(req_ch_i),
    .req_addr_i(req_addr_i), .req_rd_i(req_rd_i), .req_wdata_i(req_wdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
    .sclk_o(sclk_o), .cs_no(cs_no), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o),
    .sdio_i(sdio_i)
  );

  // slave model: presents read data after each falling edge once the header is done
  assign sdio_i = (falls >= 16 && falls < 48) ? rdv[47 - falls] : 1'b0;

  always @(negedge clk) begin
    if (!(&cs_no)) begin
      cs_cnt++;
      cs_seen = cs_seen & cs_no;
      if (sclk_o && !sclk_prev) begin
        pulses++;
        cap_d  = {cap_d[46:0], sdio_o};
        cap_oe = {cap_oe[46:0], sdio_oe_o};
        if (pulses == 17) gap_lo = lo_run;
        else if (lo_run != H) lo_bad++;
        lo_run = 0;
      end
      if (!sclk_o && sclk_prev) begin
        falls++;
        if (hi_run != H) hi_bad++;
        hi_run = 0;
      end
      if (sclk_o) hi_run++; else lo_run++;
    end
    sclk_prev = sclk_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    cs_cnt = 0; pulses = 0; falls = 0; lo_run = 0; hi_run = 0;
    lo_bad = 0; hi_bad = 0; gap_lo = 0; cap_d = '0; cap_oe = '0; cs_seen = '1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(&cs_no, "R1 cs idle", 64'(cs_no), 64'h3);
    chk(!sclk_o && !sdio_oe_o, "R1 sclk/oe", 64'({sclk_o, sdio_oe_o}), 64'h0);
    chk(!busy_o && !done_o && !err_o, "R1 busy/done/err", 64'({busy_o, done_o, err_o}), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] ch, input logic [11:0] addr, input bit rd,
                      input logic [31:0] wd, input logic [31:0] rval, input bit intrude);
    logic [31:0] prev;
    int n;
    prev = rdata_o;
    rdv = rval;
    mon_clear();
    req_valid_i = 1'b1; req_ch_i = ch; req_addr_i = addr; req_rd_i = rd; req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(busy_o, "R2 busy after accept", 64'(busy_o), 64'h1);
    if (intrude) begin
      repeat (30) @(negedge clk);
      req_valid_i = 1'b1; req_ch_i = ~ch & 2'b01; req_addr_i = ~addr; req_rd_i = ~rd;
      req_wdata_i = ~wd;
      @(negedge clk);
      req_valid_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 1000) begin @(negedge clk); n++; end
    chk(done_o, "R8 done seen", 64'(done_o), 64'h1);
    chk(!busy_o && (&cs_no), "R8 idle at done", 64'({busy_o, cs_no}), 64'h3);
    chk(cs_cnt == 97*H, "R8 cs low cycles", 64'(cs_cnt), 64'(97*H));
    chk(cs_seen == ~(2'b01 << ch), "R2 selected cs", 64'(cs_seen), 64'(~(2'b01 << ch)));
    chk(pulses == 48, "R6 pulse count", 64'(pulses), 64'd48);
    chk(lo_bad == 0 && hi_bad == 0, "R6 half widths", 64'({lo_bad, hi_bad}), 64'h0);
    chk(gap_lo == 2*H, "R7 header gap", 64'(gap_lo), 64'(2*H));
    chk(cap_d[47:32] == {addr, rd, 3'b000}, "R3 header", 64'(cap_d[47:32]), 64'({addr, rd, 3'b000}));
    chk(cap_oe[47:32] == 16'hffff, "R3 header oe", 64'(cap_oe[47:32]), 64'hffff);
    if (rd) begin
      chk(cap_oe[31:0] == 32'h0, "R5 data released", 64'(cap_oe[31:0]), 64'h0);
      chk(rdata_o == rval, "R5 read data", 64'(rdata_o), 64'(rval));
    end else begin
      chk(cap_d[31:0] == wd, "R4 write data", 64'(cap_d[31:0]), 64'(wd));
      chk(cap_oe[31:0] == 32'hffffffff, "R4 data oe", 64'(cap_oe[31:0]), 64'hffffffff);
      chk(rdata_o == prev, "R11 rdata kept", 64'(rdata_o), 64'(prev));
    end
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", 64'(done_o), 64'h0);
    if (intrude) begin
      repeat (4) @(negedge clk);
      chk(!busy_o && (&cs_no), "R10 no second frame", 64'({busy_o, cs_no}), 64'h3);
    end
  endtask

  task automatic t_bad_ch(input logic [1:0] ch);
    mon_clear();
    req_valid_i = 1'b1; req_ch_i = ch; req_addr_i = 12'h123; req_rd_i = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(err_o && !busy_o, "R9 err pulse", 64'({err_o, busy_o}), 64'h2);
    @(negedge clk);
    chk(!err_o, "R9 err one cycle", 64'(err_o), 64'h0);
    repeat (3) @(negedge clk);
    chk(cs_cnt == 0 && !busy_o, "R9 no cs", 64'(cs_cnt), 64'h0);
  endtask

  initial begin
    t_reset();
    xfer(2'd0, 12'hA5C, 1'b0, 32'hDEADBEEF, 32'h0, 1'b0);
    xfer(2'd1, 12'h3F1, 1'b1, 32'h0, 32'h8123_4567, 1'b0);
    xfer(2'd0, 12'h001, 1'b1, 32'hFFFF_FFFF, 32'h5A5A_00FF, 1'b0);
    xfer(2'd1, 12'hFFF, 1'b0, 32'h0000_0001, 32'h0, 1'b0);
    t_bad_ch(2'd2);
    t_bad_ch(2'd3);
    xfer(2'd0, 12'h800, 1'b0, 32'h1357_9BDF, 32'h0, 1'b1);
    xfer(2'd1, 12'h07E, 1'b1, 32'h0, 32'h0F0F_F0F0, 1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule